// File: doc/BRIEF.md
# Least-Recently-Issued Thread Selector

This block chooses, every cycle, which of several hardware threads that share one single-issue pipeline may issue an instruction to decode, and which may fetch into its instruction buffer. Both choices come from one age order kept across the threads. The thread that issued longest ago wins among the candidates, so with several ready threads the pipeline moves to a different thread on each cycle. The order changes only when a thread actually issues.

A thread drops out of the issue choice in several cases: it has no instruction, it waits on a cache miss, it has a pending trap or interrupt, or it needs the shared divider/FPU while that unit is busy. Threads that do not need the shared unit go on issuing. After a thread issues a load, it enters a short window that lasts until the load result is usable. In that window the thread is held if its next instruction depends on the load. Otherwise the next instruction may go out speculatively, on the assumption that the load hits, but it does so only when no ordinary candidate exists. If a miss is then reported for that thread, the block asks for a flush of that thread in the same cycle. The instruction is replayed later by normal issue once the miss stall lifts.

Top module: `thread_picker`

## Requirements
- R1: After reset the age order is thread 0 oldest up to thread N-1 newest, and no load window is open. With every thread ready, the first issue and the first fetch both select thread 0 (`issue_sel` = `fetch_sel` = 4'b0001 for N=4).
- R2: `issue_sel` is one-hot or zero. It selects the candidate with the oldest age rank, with ordinary candidates taking precedence over speculative ones.
- R3: When a thread issues, it becomes the newest in the age order, and every thread that was newer than it moves one step older. In a cycle with no issue the order does not change.
- R4: A thread with `miss_wait` or `trap_pend` set, or with `inst_valid` clear, is never selected for issue.
- R5: When `unit_busy` is set, a thread with `need_unit` set is not selected for issue, while other threads remain eligible.
- R6: After a thread issues a load (`issue_is_load` high in its issue cycle), that thread is held in the next LAT-1 cycles whenever `dep_load` is set for it. It becomes eligible again LAT cycles after the load issued.
- R7: A thread inside its load window with `dep_load` clear is a speculative candidate. It is selected only if no ordinary candidate exists, even if it is older.
- R8: `flush_valid` rises in the same cycle as `miss_valid` for thread `miss_tid` if that thread issued speculatively in its still-open load window, with `flush_tid` = `miss_tid` (binary thread number). A miss reported for a thread without such an issue gives no flush, and a miss closes the window.
- R9: `fetch_sel` is one-hot or zero and selects, by the same age order, the oldest thread that has `buf_space` set and neither `miss_wait` nor `trap_pend` set. Fetch does not change the order.
- R10: When no thread is eligible for issue, `issue_sel` is all zero and the age order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| inst_valid | input | N | Thread has an instruction ready to issue |
| buf_space | input | N | Thread's instruction buffer can accept a fetch |
| miss_wait | input | N | Thread stalled on an outstanding cache miss |
| trap_pend | input | N | Thread has a trap or interrupt pending |
| need_unit | input | N | Thread's next instruction needs the shared divider/FPU |
| unit_busy | input | 1 | Shared divider/FPU is occupied |
| dep_load | input | N | Thread's next instruction depends on its last load |
| issue_is_load | input | 1 | The instruction issued this cycle is a load |
| miss_valid | input | 1 | A load miss is being reported |
| miss_tid | input | log2(N) | Thread that owns the missing load |
| fetch_sel | output | N | One-hot fetch select |
| issue_sel | output | N | One-hot issue select |
| flush_valid | output | 1 | Flush request for a speculatively issued instruction |
| flush_tid | output | log2(N) | Thread to flush |

## Verification
The bench builds the block with four threads and a three-cycle load latency. With these values the age order has 24 distinct states and the load window lasts two cycles, so a directed sequence can walk a thread through a full window. In the same sequence, a speculative thread that is older than an ordinary one can be set up while the window is still open. A few thousand random cycles then mix loads, misses, traps and divider contention across all four threads, so flushes, holds and order updates overlap.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  // Issue class of one thread in the current cycle
  typedef enum logic [1:0] {
    CAND_NONE = 2'd0,  // blocked
    CAND_NORM = 2'd1,  // ordinary candidate
    CAND_SPEC = 2'd2,  // speculative candidate after a load
    CAND_HOLD = 2'd3   // held on a load hazard
  } cand_e;

  function automatic cand_e classify(input logic blocked, input logic in_win,
                                     input logic dep);
    if (blocked)     return CAND_NONE;
    else if (!in_win) return CAND_NORM;
    else if (dep)    return CAND_HOLD;
    else             return CAND_SPEC;
  endfunction
endpackage

// File: rtl/tsel_lru.sv
module tsel_lru #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         fetch_req,
  input  logic [N-1:0]         norm_req,
  input  logic [N-1:0]         spec_req,
  input  logic                 upd_en,
  input  logic [N-1:0]         upd_sel,
  output logic [N-1:0]         fetch_pick,
  output logic [N-1:0]         issue_pick,
  output logic [N*((N>1)?$clog2(N):1)-1:0] rank_flat
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic [RW-1:0] rk [N];
  logic [RW-1:0] upd_rank;

  // Lowest rank among requesters wins (rank 0 = issued longest ago)
  function automatic logic [N-1:0] pick_oldest(input logic [N-1:0] req,
                                               input logic [N*RW-1:0] rf);
    logic [N-1:0]  sel;
    logic [RW-1:0] best;
    logic          found;
    sel   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || rf[i*RW +: RW] < best)) begin
        sel    = '0;
        sel[i] = 1'b1;
        best   = rf[i*RW +: RW];
        found  = 1'b1;
      end
    end
    return sel;
  endfunction

  always_comb begin
    upd_rank = '0;
    for (int i = 0; i < N; i++)
      if (upd_sel[i]) upd_rank = upd_rank | rk[i];
  end

  assign fetch_pick = pick_oldest(fetch_req, rank_flat);
  assign issue_pick = (|norm_req) ? pick_oldest(norm_req, rank_flat)
                                  : pick_oldest(spec_req, rank_flat);

  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rk[g] <= RW'(g);
      else if (upd_en) begin
        if (upd_sel[g])
          rk[g] <= RW'(N - 1);
        else if (rk[g] > upd_rank)
          rk[g] <= rk[g] - 1'b1;
      end
    end
    assign rank_flat[g*RW +: RW] = rk[g];
  end
endmodule

// File: rtl/tsel_loadtrack.sv
module tsel_loadtrack #(
  parameter int N   = 4,
  parameter int LAT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  issue_sel,
  input  logic                          issue_is_load,
  input  logic                          miss_valid,
  input  logic [((N>1)?$clog2(N):1)-1:0] miss_tid,
  output logic [N-1:0]                  in_window,
  output logic [N-1:0]                  spec_flag,
  output logic                          flush_valid,
  output logic [((N>1)?$clog2(N):1)-1:0] flush_tid
);
  localparam int TW = (N > 1) ? $clog2(N) : 1;
  localparam int WW = $clog2(LAT + 1);
  localparam logic [WW-1:0] WIN_START = WW'(LAT - 1);

  for (genvar t = 0; t < N; t++) begin : g_thr
    logic [WW-1:0] win;
    logic          spec;
    logic          miss_here;

    assign miss_here = miss_valid && (miss_tid == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win  <= '0;
        spec <= 1'b0;
      end else if (miss_here) begin
        win  <= '0;
        spec <= 1'b0;
      end else if (issue_sel[t] && issue_is_load) begin
        win  <= WIN_START;
        spec <= (win != '0);
      end else if (win != '0) begin
        win  <= win - 1'b1;
        spec <= (win == WW'(1)) ? 1'b0 : (spec | issue_sel[t]);
      end
    end

    assign in_window[t] = (win != '0);
    assign spec_flag[t] = spec;
  end

  assign flush_valid = miss_valid && spec_flag[miss_tid];
  assign flush_tid   = miss_tid;
endmodule

// File: rtl/thread_picker.sv
module thread_picker #(
  parameter int N   = 4,
  parameter int LAT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  inst_valid,
  input  logic [N-1:0]                  buf_space,
  input  logic [N-1:0]                  miss_wait,
  input  logic [N-1:0]                  trap_pend,
  input  logic [N-1:0]                  need_unit,
  input  logic                          unit_busy,
  input  logic [N-1:0]                  dep_load,
  input  logic                          issue_is_load,
  input  logic                          miss_valid,
  input  logic [((N>1)?$clog2(N):1)-1:0] miss_tid,
  output logic [N-1:0]                  fetch_sel,
  output logic [N-1:0]                  issue_sel,
  output logic                          flush_valid,
  output logic [((N>1)?$clog2(N):1)-1:0] flush_tid
);
  import tsel_pkg::*;
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  // Named internal events for the checker
  logic [N-1:0]    in_window;
  logic [N-1:0]    spec_flag;
  logic [N-1:0]    norm_req;
  logic [N-1:0]    spec_req;
  logic [N-1:0]    fetch_req;
  logic [N*RW-1:0] rank_flat;
  logic            issue_fire;
  cand_e           cls [N];

  for (genvar t = 0; t < N; t++) begin : g_cls
    logic blocked;
    assign blocked     = !inst_valid[t] || miss_wait[t] || trap_pend[t] ||
                         (need_unit[t] && unit_busy);
    assign cls[t]      = classify(blocked, in_window[t], dep_load[t]);
    assign norm_req[t] = (cls[t] == CAND_NORM);
    assign spec_req[t] = (cls[t] == CAND_SPEC);
  end

  assign fetch_req  = buf_space & ~miss_wait & ~trap_pend;
  assign issue_fire = |issue_sel;

  tsel_lru #(.N(N)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .norm_req   (norm_req),
    .spec_req   (spec_req),
    .upd_en     (issue_fire),
    .upd_sel    (issue_sel),
    .fetch_pick (fetch_sel),
    .issue_pick (issue_sel),
    .rank_flat  (rank_flat)
  );

  tsel_loadtrack #(.N(N), .LAT(LAT)) u_ld (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_sel     (issue_sel),
    .issue_is_load (issue_is_load),
    .miss_valid    (miss_valid),
    .miss_tid      (miss_tid),
    .in_window     (in_window),
    .spec_flag     (spec_flag),
    .flush_valid   (flush_valid),
    .flush_tid     (flush_tid)
  );
endmodule

// File: rtl/thread_picker_chk.sv
module thread_picker_chk #(
  parameter int N   = 4,
  parameter int LAT = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [N-1:0]                      inst_valid,
  input logic [N-1:0]                      buf_space,
  input logic [N-1:0]                      miss_wait,
  input logic [N-1:0]                      trap_pend,
  input logic [N-1:0]                      need_unit,
  input logic                              unit_busy,
  input logic [N-1:0]                      dep_load,
  input logic                              issue_is_load,
  input logic                              miss_valid,
  input logic [N-1:0]                      fetch_sel,
  input logic [N-1:0]                      issue_sel,
  input logic                              flush_valid,
  input logic [N-1:0]                      norm_req,
  input logic [N-1:0]                      spec_req,
  input logic                              issue_fire,
  input logic [N*((N>1)?$clog2(N):1)-1:0]  rank_flat
);
  assert_issue_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_sel));

  assert_order_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_fire |=> $stable(rank_flat));

  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_sel & (miss_wait | trap_pend | ~inst_valid)) == '0);

  assert_unit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unit_busy |-> ((issue_sel & need_unit) == '0));

  assert_load_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 1 && issue_fire && issue_is_load && !miss_valid)
      |=> ((issue_sel & $past(issue_sel) & dep_load) == '0));

  assert_spec_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|norm_req) |-> ((issue_sel & spec_req) == '0));

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> miss_valid);

  assert_fetch_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_sel) && ((fetch_sel & (miss_wait | trap_pend | ~buf_space)) == '0));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid == '0) |-> (issue_sel == '0));
endmodule

bind thread_picker thread_picker_chk #(.N(N), .LAT(LAT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inst_valid    (inst_valid),
  .buf_space     (buf_space),
  .miss_wait     (miss_wait),
  .trap_pend     (trap_pend),
  .need_unit     (need_unit),
  .unit_busy     (unit_busy),
  .dep_load      (dep_load),
  .issue_is_load (issue_is_load),
  .miss_valid    (miss_valid),
  .fetch_sel     (fetch_sel),
  .issue_sel     (issue_sel),
  .flush_valid   (flush_valid),
  .norm_req      (norm_req),
  .spec_req      (spec_req),
  .issue_fire    (issue_fire),
  .rank_flat     (rank_flat)
);

// File: tb/thread_picker_tb.sv
module thread_picker_tb;
  localparam int N   = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] inst_valid = '0, buf_space = '0, miss_wait = '0, trap_pend = '0;
  logic [N-1:0] need_unit = '0, dep_load = '0;
  logic unit_busy = 1'b0, issue_is_load = 1'b0, miss_valid = 1'b0;
  logic [1:0] miss_tid = '0;
  logic [N-1:0] fetch_sel, issue_sel;
  logic flush_valid;
  logic [1:0] flush_tid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  int  m_rank [N];
  int  m_win  [N];
  bit  m_spec [N];
  logic [N-1:0] e_issue, e_fetch;
  logic e_fv;

  always #5 clk = ~clk;

  thread_picker #(.N(N), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .buf_space(buf_space),
    .miss_wait(miss_wait), .trap_pend(trap_pend), .need_unit(need_unit),
    .unit_busy(unit_busy), .dep_load(dep_load), .issue_is_load(issue_is_load),
    .miss_valid(miss_valid), .miss_tid(miss_tid), .fetch_sel(fetch_sel),
    .issue_sel(issue_sel), .flush_valid(flush_valid), .flush_tid(flush_tid));

  // Walk ranks from oldest upward; first requester found wins
  function automatic logic [N-1:0] oldest_of(input logic [N-1:0] req);
    for (int k = 0; k < N; k++)
      for (int t = 0; t < N; t++)
        if (m_rank[t] == k && req[t]) return 4'(1 << t);
    return '0;
  endfunction

  task automatic model_expect();
    logic [N-1:0] ord, spc;
    ord = '0; spc = '0;
    for (int t = 0; t < N; t++) begin
      if (inst_valid[t] && !miss_wait[t] && !trap_pend[t] && !(need_unit[t] && unit_busy)) begin
        if (m_win[t] == 0) ord[t] = 1'b1;
        else if (!dep_load[t]) spc[t] = 1'b1;
      end
    end
    e_issue = (ord != '0) ? oldest_of(ord) : oldest_of(spc);
    e_fetch = oldest_of(buf_space & ~miss_wait & ~trap_pend);
    e_fv    = miss_valid && m_spec[miss_tid];
  endtask

  task automatic model_advance();
    int who;
    who = -1;
    for (int t = 0; t < N; t++) if (e_issue[t]) who = t;
    for (int t = 0; t < N; t++) begin
      if (miss_valid && miss_tid == 2'(t)) begin
        m_win[t] = 0; m_spec[t] = 0;
      end else if (who == t && issue_is_load) begin
        m_spec[t] = (m_win[t] != 0);
        m_win[t]  = LAT - 1;
      end else if (m_win[t] != 0) begin
        if (m_win[t] == 1) m_spec[t] = 0;
        else if (who == t) m_spec[t] = 1;
        m_win[t] = m_win[t] - 1;
      end
    end
    if (who >= 0) begin
      int old;
      old = m_rank[who];
      for (int t = 0; t < N; t++)
        if (t == who) m_rank[t] = N - 1;
        else if (m_rank[t] > old) m_rank[t] = m_rank[t] - 1;
    end
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Compare all outputs with the model, then clock one cycle
  task automatic step(input string tag);
    #1;
    model_expect();
    chk({tag, " issue"}, issue_sel, e_issue);
    chk({tag, " fetch"}, fetch_sel, e_fetch);
    chk({tag, " flush"}, {3'b0, flush_valid}, {3'b0, e_fv});
    if (e_fv) chk({tag, " flush_tid"}, {2'b0, flush_tid}, {2'b0, miss_tid});
    @(posedge clk);
    model_advance();
    @(negedge clk);
  endtask

  task automatic set_in(input logic [N-1:0] v, input logic ld);
    inst_valid = v; buf_space = '1; miss_wait = '0; trap_pend = '0;
    need_unit = '0; unit_busy = 0; dep_load = '0; issue_is_load = ld;
    miss_valid = 0; miss_tid = '0;
  endtask

  initial begin
    for (int t = 0; t < N; t++) begin m_rank[t] = t; m_win[t] = 0; m_spec[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset order, thread 0 first for issue and fetch
    set_in(4'b1111, 0); #1;
    chk("R1 issue", issue_sel, 4'b0001);
    chk("R1 fetch", fetch_sel, 4'b0001);
    step("R1");
    // R3: thread 0 became newest, thread 1 is now oldest
    set_in(4'b1111, 0); #1; chk("R3 issue", issue_sel, 4'b0010); step("R3");
    // R4: trap on 2, miss wait on 3
    set_in(4'b1111, 0); trap_pend = 4'b0100; miss_wait = 4'b1000; #1;
    chk("R4 issue", issue_sel, 4'b0001); chk("R9 fetch", fetch_sel, 4'b0001); step("R4");
    // R5: unit busy blocks thread 2 only
    set_in(4'b1111, 0); unit_busy = 1; need_unit = 4'b0100; #1;
    chk("R5 issue", issue_sel, 4'b1000); step("R5");
    // R10 / R9: nothing ready, fetch still picks oldest (thread 2)
    set_in(4'b0000, 0); #1;
    chk("R10 issue", issue_sel, 4'b0000); chk("R9 fetch idle", fetch_sel, 4'b0100); step("R10");
    // R6: load by thread 2, then dependent instruction waits two cycles
    set_in(4'b0100, 1); #1; chk("R6 load", issue_sel, 4'b0100); step("R6");
    set_in(4'b0100, 0); dep_load = 4'b0100; #1; chk("R6 hold1", issue_sel, 4'b0000); step("R6");
    set_in(4'b0100, 0); dep_load = 4'b0100; #1; chk("R6 hold2", issue_sel, 4'b0000); step("R6");
    set_in(4'b0100, 0); dep_load = 4'b0100; #1; chk("R6 free", issue_sel, 4'b0100); step("R6");
    // R8: load by thread 1, speculative successor, then miss -> flush thread 1
    set_in(4'b1111, 1); #1; chk("R8 load", issue_sel, 4'b0010); step("R8");
    set_in(4'b0010, 0); #1; chk("R8 spec", issue_sel, 4'b0010); step("R8");
    set_in(4'b0000, 0); miss_valid = 1; miss_tid = 2'd1; #1;
    chk("R8 flush", {3'b0, flush_valid}, 4'b0001); chk("R8 tid", {2'b0, flush_tid}, 4'b0001); step("R8");
    // R7: older speculative thread 0 loses to newer ordinary thread 3
    set_in(4'b1111, 1); #1; chk("R7 load", issue_sel, 4'b0001); step("R7");
    set_in(4'b1001, 0); #1; chk("R7 pre", issue_sel, 4'b1000); step("R7");
    set_in(4'b1001, 0); #1; chk("R7 prio", issue_sel, 4'b1000); step("R7");
    // R8: miss after the window closed gives no flush
    set_in(4'b0000, 0); miss_valid = 1; miss_tid = 2'd0; #1;
    chk("R8 noflush", {3'b0, flush_valid}, 4'b0000); step("R8");

    // Random mix against the model: R2 R3 R4 R5 R6 R7 R8 R9 R10
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      inst_valid    = 4'($urandom) | 4'($urandom);
      buf_space     = 4'($urandom);
      miss_wait     = 4'($urandom) & 4'($urandom) & 4'($urandom);
      trap_pend     = 4'($urandom) & 4'($urandom) & 4'($urandom);
      need_unit     = 4'($urandom) & 4'($urandom);
      unit_busy     = ($urandom % 3) == 0;
      dep_load      = 4'($urandom);
      issue_is_load = ($urandom % 3) == 0;
      miss_valid    = ($urandom % 6) == 0;
      miss_tid      = 2'($urandom);
      step("R2 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule